// File: doc/BRIEF.md
# Configuration Access Router

This block takes configuration accesses from a single host port and steers each one to a destination. An access carries a 24-bit address, write data, a read/write flag and a byte length of 1, 2 or 4. The address splits into a bus number, a device/function number and a register offset. The device/function number is the slot times eight plus the function, so the slot sits in its upper five bits and the function in its lower three.

An access to the bus this router owns reaches the local function register port only if the presence vector marks that device/function as populated. An access whose bus number equals the secondary bus number of the attached bridge goes out, unchanged, on a separate downstream port. Every other access is a miss. A read miss returns all ones trimmed to the access length. A write miss has no effect.

The router keeps the bridge's secondary bus number itself. It updates the value by watching writes to the bridge function's bus-number registers. Those writes still reach the bridge's own registers as well. Only one access is in flight at a time, and a one-cycle done pulse closes each access.

Top module: `cfg_router`

## Requirements
- R1: A local access presents device/function = address bits [15:8] (slot [15:11], function [10:8]) and offset = address bits [7:0] on the function port, with its length, write flag and write data unchanged.
- R2: An access is local only when address bits [23:16] equal LOCAL_BUS and `fn_present[devfn]` is 1. Otherwise, on the local bus, it is a miss.
- R3: A read miss completes with `rdata` = 0x000000FF for length 1, 0x0000FFFF for length 2, and 0xFFFFFFFF for length 4 (any other length code is treated as 4).
- R4: A write miss strobes neither port and leaves the secondary bus number unchanged.
- R5: A local write to BRIDGE_DEVFN at offset 0x19, of any length, sets the secondary bus number to write data bits [7:0].
- R6: A local write to BRIDGE_DEVFN at offset 0x18 with length greater than 1 sets the secondary bus number to write data bits [15:8]. A length-1 write there leaves it unchanged.
- R7: Bridge bus-number writes are still forwarded on the function port.
- R8: An access whose bus number equals the secondary bus number, and is not LOCAL_BUS, is forwarded on the downstream port with the full 24-bit address, data, length and write flag. The downstream read data is returned.
- R9: The secondary bus number resets to 0. The local bus takes priority when the two numbers are equal.
- R10: `done` is a single-cycle pulse. It follows a port's ready by one cycle, or follows acceptance of a miss by one cycle. `req_ready` is low while an access is in flight or `done` is high. At most one port strobe is active at a time.
- R11: While the function port strobe waits for ready, its device/function and offset hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host access request |
| req_ready | output | 1 | Router can accept an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Bus [23:16], device/function [15:8], offset [7:0] |
| req_wdata | input | 32 | Write data |
| req_len | input | 3 | Byte length 1, 2 or 4 |
| done | output | 1 | Access complete pulse |
| rdata | output | 32 | Read result, valid with done on reads |
| fn_present | input | 256 | Populated flag per device/function |
| fn_valid | output | 1 | Local function access strobe |
| fn_ready | input | 1 | Local function has answered |
| fn_write | output | 1 | Local write flag |
| fn_devfn | output | 8 | Selected device/function |
| fn_offset | output | 8 | Register offset |
| fn_wdata | output | 32 | Local write data |
| fn_len | output | 3 | Local access length |
| fn_rdata | input | 32 | Local read data |
| ds_valid | output | 1 | Downstream access strobe |
| ds_ready | input | 1 | Downstream has answered |
| ds_write | output | 1 | Downstream write flag |
| ds_addr | output | 24 | Downstream full address |
| ds_wdata | output | 32 | Downstream write data |
| ds_len | output | 3 | Downstream length |
| ds_rdata | input | 32 | Downstream read data |

## Verification
The hardest cases to reach are those where steering depends on a secondary bus number that the bench can set only by indirect means: through bridge writes at the right offsets and lengths. Directed sequences load the number with an offset-0x19 write, then an offset-0x18 two-byte write, and then attempt a one-byte write at 0x18 that must not change it. Each step is followed by accesses whose destination reveals the stored value. Random traffic then biases its bus numbers toward the local bus and the current secondary bus. A random presence map produces hits and misses in a mix, and the function responder takes a random number of wait cycles.

// File: rtl/cfg_router_pkg.sv
package cfg_router_pkg;
  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_LOCAL = 2'd1,
    TGT_DOWN  = 2'd2
  } target_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOCAL = 2'd1,
    ST_DOWN  = 2'd2
  } state_e;

  localparam logic [7:0] OFF_BUS_PAIR = 8'h18;
  localparam logic [7:0] OFF_SEC_BUS  = 8'h19;
endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
  import cfg_router_pkg::*;
#(
  parameter int BUS_W   = 8,
  parameter int DEVFN_W = 8,
  parameter int OFF_W   = 8,
  parameter logic [BUS_W-1:0] LOCAL_BUS = '0,
  localparam int ADDR_W = BUS_W + DEVFN_W + OFF_W,
  localparam int NUM_FN = 1 << DEVFN_W
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BUS_W-1:0]   sec_bus,
  input  logic [NUM_FN-1:0]  present,
  output logic [DEVFN_W-1:0] devfn,
  output logic [OFF_W-1:0]   offset,
  output target_e            target
);
  logic [BUS_W-1:0] bus;

  assign bus    = addr[ADDR_W-1 -: BUS_W];
  assign devfn  = addr[OFF_W +: DEVFN_W];
  assign offset = addr[OFF_W-1:0];

  always_comb begin
    if (bus == LOCAL_BUS) begin
      target = present[devfn] ? TGT_LOCAL : TGT_NONE;
    end else if (bus == sec_bus) begin
      target = TGT_DOWN;
    end else begin
      target = TGT_NONE;
    end
  end
endmodule

// File: rtl/cfg_bridge_busnum.sv
module cfg_bridge_busnum
  import cfg_router_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int OFF_W  = 8,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [OFF_W-1:0]  offset,
  input  logic [LEN_W-1:0]  len,
  input  logic [DATA_W-1:0] wdata,
  output logic [BUS_W-1:0]  sec_bus
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sec_bus <= '0;
    end else if (cap_en) begin
      if (offset == OFF_W'(OFF_SEC_BUS)) begin
        sec_bus <= wdata[BUS_W-1:0];
      end else if (offset == OFF_W'(OFF_BUS_PAIR) && len > LEN_W'(1)) begin
        sec_bus <= wdata[BUS_W +: BUS_W];
      end
    end
  end
endmodule

// File: rtl/cfg_miss_fill.sv
module cfg_miss_fill #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 3
) (
  input  logic [LEN_W-1:0]  len,
  output logic [DATA_W-1:0] fill
);
  localparam int NBYTES = DATA_W / 8;

  always_comb begin
    fill = '0;
    for (int b = 0; b < NBYTES; b++) begin
      if (len == LEN_W'(1)) begin
        if (b < 1) fill[b*8 +: 8] = 8'hFF;
      end else if (len == LEN_W'(2)) begin
        if (b < 2) fill[b*8 +: 8] = 8'hFF;
      end else begin
        fill[b*8 +: 8] = 8'hFF;
      end
    end
  end
endmodule

// File: rtl/cfg_router.sv
module cfg_router
  import cfg_router_pkg::*;
#(
  parameter int BUS_W   = 8,
  parameter int DEVFN_W = 8,
  parameter int OFF_W   = 8,
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 3,
  parameter logic [BUS_W-1:0]   LOCAL_BUS    = 8'h00,
  parameter logic [DEVFN_W-1:0] BRIDGE_DEVFN = 8'h08,
  localparam int ADDR_W = BUS_W + DEVFN_W + OFF_W,
  localparam int NUM_FN = 1 << DEVFN_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [LEN_W-1:0]   req_len,
  output logic               done,
  output logic [DATA_W-1:0]  rdata,
  input  logic [NUM_FN-1:0]  fn_present,
  output logic               fn_valid,
  input  logic               fn_ready,
  output logic               fn_write,
  output logic [DEVFN_W-1:0] fn_devfn,
  output logic [OFF_W-1:0]   fn_offset,
  output logic [DATA_W-1:0]  fn_wdata,
  output logic [LEN_W-1:0]   fn_len,
  input  logic [DATA_W-1:0]  fn_rdata,
  output logic               ds_valid,
  input  logic               ds_ready,
  output logic               ds_write,
  output logic [ADDR_W-1:0]  ds_addr,
  output logic [DATA_W-1:0]  ds_wdata,
  output logic [LEN_W-1:0]   ds_len,
  input  logic [DATA_W-1:0]  ds_rdata
);
  state_e               state;
  target_e              tgt;
  logic [DEVFN_W-1:0]   dec_devfn;
  logic [OFF_W-1:0]     dec_offset;
  logic [BUS_W-1:0]     sec_bus;
  logic [DATA_W-1:0]    miss_fill;
  logic                 accept;
  logic                 bridge_cap;

  cfg_addr_decode #(
    .BUS_W(BUS_W), .DEVFN_W(DEVFN_W), .OFF_W(OFF_W), .LOCAL_BUS(LOCAL_BUS)
  ) u_dec (
    .addr(req_addr), .sec_bus(sec_bus), .present(fn_present),
    .devfn(dec_devfn), .offset(dec_offset), .target(tgt)
  );

  cfg_miss_fill #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_fill (
    .len(req_len), .fill(miss_fill)
  );

  assign req_ready  = (state == ST_IDLE) && !done;
  assign accept     = req_valid && req_ready;
  assign bridge_cap = accept && req_write && (tgt == TGT_LOCAL) &&
                      (dec_devfn == BRIDGE_DEVFN);

  cfg_bridge_busnum #(
    .BUS_W(BUS_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .LEN_W(LEN_W)
  ) u_bridge (
    .clk(clk), .rst(rst), .cap_en(bridge_cap), .offset(dec_offset),
    .len(req_len), .wdata(req_wdata), .sec_bus(sec_bus)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      done      <= 1'b0;
      rdata     <= '0;
      fn_valid  <= 1'b0;
      fn_write  <= 1'b0;
      fn_devfn  <= '0;
      fn_offset <= '0;
      fn_wdata  <= '0;
      fn_len    <= '0;
      ds_valid  <= 1'b0;
      ds_write  <= 1'b0;
      ds_addr   <= '0;
      ds_wdata  <= '0;
      ds_len    <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            unique case (tgt)
              TGT_LOCAL: begin
                fn_valid  <= 1'b1;
                fn_write  <= req_write;
                fn_devfn  <= dec_devfn;
                fn_offset <= dec_offset;
                fn_wdata  <= req_wdata;
                fn_len    <= req_len;
                state     <= ST_LOCAL;
              end
              TGT_DOWN: begin
                ds_valid <= 1'b1;
                ds_write <= req_write;
                ds_addr  <= req_addr;
                ds_wdata <= req_wdata;
                ds_len   <= req_len;
                state    <= ST_DOWN;
              end
              default: begin
                done <= 1'b1;
                if (!req_write) rdata <= miss_fill;
              end
            endcase
          end
        end
        ST_LOCAL: begin
          if (fn_ready) begin
            fn_valid <= 1'b0;
            done     <= 1'b1;
            if (!fn_write) rdata <= fn_rdata;
            state    <= ST_IDLE;
          end
        end
        ST_DOWN: begin
          if (ds_ready) begin
            ds_valid <= 1'b0;
            done     <= 1'b1;
            if (!ds_write) rdata <= ds_rdata;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_router_chk.sv
module cfg_router_chk
  import cfg_router_pkg::*;
#(
  parameter int BUS_W   = 8,
  parameter int DEVFN_W = 8,
  parameter int OFF_W   = 8,
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_write,
  input logic [LEN_W-1:0]   req_len,
  input logic               done,
  input logic [DATA_W-1:0]  rdata,
  input logic               fn_valid,
  input logic               fn_ready,
  input logic [DEVFN_W-1:0] fn_devfn,
  input logic [OFF_W-1:0]   fn_offset,
  input logic               ds_valid,
  input logic               ds_ready,
  input target_e            tgt,
  input logic [BUS_W-1:0]   sec_bus
);
  logic acc;
  assign acc = req_valid && req_ready;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  one_port_chk: assert property (@(posedge clk) disable iff (rst)
    !(fn_valid && ds_valid));

  // R10
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    (fn_valid || ds_valid) |-> !req_ready);

  // R10
  resp_done_chk: assert property (@(posedge clk) disable iff (rst)
    ((fn_valid && fn_ready) || (ds_valid && ds_ready)) |=> done);

  // R11
  fn_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fn_valid && !fn_ready) |=> (fn_valid && $stable(fn_devfn) && $stable(fn_offset)));

  // R3
  miss_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !req_write && tgt == TGT_NONE) |=>
      (done && rdata == (($past(req_len) == LEN_W'(1)) ? DATA_W'(32'h000000FF) :
                         ($past(req_len) == LEN_W'(2)) ? DATA_W'(32'h0000FFFF) :
                                                         {DATA_W{1'b1}})));

  // R4
  miss_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && req_write && tgt == TGT_NONE) |=>
      (!fn_valid && !ds_valid && done && $stable(sec_bus)));
endmodule

bind cfg_router cfg_router_chk #(
  .BUS_W(BUS_W), .DEVFN_W(DEVFN_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_len(req_len), .done(done), .rdata(rdata),
  .fn_valid(fn_valid), .fn_ready(fn_ready), .fn_devfn(fn_devfn),
  .fn_offset(fn_offset), .ds_valid(ds_valid), .ds_ready(ds_ready),
  .tgt(tgt), .sec_bus(sec_bus)
);

// File: tb/cfg_router_test.sv
module cfg_router_test;
  localparam logic [7:0] LOCAL  = 8'h00;
  localparam logic [7:0] BRIDGE = 8'h08;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [2:0]  req_len = 3'd4;
  logic        req_ready, done;
  logic [31:0] rdata;
  logic [255:0] fn_present;
  logic        fn_valid, fn_write, ds_valid, ds_write;
  logic        fn_ready = 1'b0, ds_ready = 1'b0;
  logic [7:0]  fn_devfn, fn_offset;
  logic [31:0] fn_wdata, ds_wdata, fn_rdata, ds_rdata;
  logic [2:0]  fn_len, ds_len;
  logic [23:0] ds_addr;

  assign fn_rdata = {fn_devfn, fn_offset, 16'hC35A};
  assign ds_rdata = {8'h5D, ds_addr};

  cfg_router #(.LOCAL_BUS(LOCAL), .BRIDGE_DEVFN(BRIDGE)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_len(req_len), .done(done), .rdata(rdata), .fn_present(fn_present),
    .fn_valid(fn_valid), .fn_ready(fn_ready), .fn_write(fn_write),
    .fn_devfn(fn_devfn), .fn_offset(fn_offset), .fn_wdata(fn_wdata),
    .fn_len(fn_len), .fn_rdata(fn_rdata), .ds_valid(ds_valid),
    .ds_ready(ds_ready), .ds_write(ds_write), .ds_addr(ds_addr),
    .ds_wdata(ds_wdata), .ds_len(ds_len), .ds_rdata(ds_rdata)
  );

  int checks = 0, fails = 0;
  int fn_cnt = 0, ds_cnt = 0;
  logic [7:0]  seen_devfn, seen_off;
  logic [31:0] seen_wdata;
  logic [2:0]  seen_len;
  logic        seen_write;
  logic [23:0] seen_daddr;
  logic [7:0]  model_sec = 8'h00;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Responders: random wait on the function port, fixed one on downstream; done-timing monitor.
  bit fn_prev = 0, ds_prev = 0, resp_seen = 0;
  int fn_wait = 0;
  always @(negedge clk) begin
    if (resp_seen && !rst)
      check(done == 1'b1, "R10 done follows ready", 32'(done), 32'd1);
    resp_seen = (fn_valid && fn_ready) || (ds_valid && ds_ready);
    if (fn_valid && !fn_prev) begin
      fn_cnt++;
      seen_devfn = fn_devfn; seen_off = fn_offset; seen_wdata = fn_wdata;
      seen_len = fn_len; seen_write = fn_write;
      fn_wait = $urandom % 3;
    end
    if (ds_valid && !ds_prev) begin
      ds_cnt++;
      seen_daddr = ds_addr; seen_wdata = ds_wdata; seen_len = ds_len; seen_write = ds_write;
    end
    fn_prev = fn_valid; ds_prev = ds_valid;
    if (fn_valid) begin
      if (fn_wait == 0) fn_ready = 1'b1; else fn_wait--;
    end else fn_ready = 1'b0;
    ds_ready = ds_valid;
  end

  function automatic logic [31:0] fill_of(input logic [2:0] len);
    if (len == 3'd1) return 32'h000000FF;
    if (len == 3'd2) return 32'h0000FFFF;
    return 32'hFFFFFFFF;
  endfunction

  task automatic access(input bit wr, input logic [23:0] addr, input logic [31:0] wd, input logic [2:0] len);
    int f0 = fn_cnt, d0 = ds_cnt, n = 0;
    logic [7:0] bus = addr[23:16], df = addr[15:8], off = addr[7:0];
    bit local_hit = (bus == LOCAL) && fn_present[df];
    bit down = (bus != LOCAL) && (bus == model_sec);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd; req_len = len;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && n < 50) begin @(negedge clk); n++; end
    check(done == 1'b1, "R10 access completes", 32'(done), 32'd1);
    if (local_hit) begin
      check(fn_cnt == f0 + 1 && ds_cnt == d0, "R2 local hit routed", 32'(fn_cnt - f0), 32'd1);
      check({seen_devfn, seen_off} == {df, off}, "R1 fields", {16'h0, seen_devfn, seen_off}, {16'h0, df, off});
      check(seen_len == len && seen_write == wr, "R1 len/write", {28'h0, seen_write, seen_len}, {28'h0, wr, len});
      if (wr) begin
        check(seen_wdata == wd, "R1 wdata", seen_wdata, wd);
        if (df == BRIDGE) begin
          if (off == 8'h19) model_sec = wd[7:0];
          else if (off == 8'h18 && len > 3'd1) model_sec = wd[15:8];
        end
      end else check(rdata == {df, off, 16'hC35A}, "R1 read data", rdata, {df, off, 16'hC35A});
    end else if (down) begin
      check(ds_cnt == d0 + 1 && fn_cnt == f0, "R8 downstream routed", 32'(ds_cnt - d0), 32'd1);
      check(seen_daddr == addr && seen_len == len && seen_write == wr, "R8 downstream addr",
            {8'h0, seen_daddr}, {8'h0, addr});
      if (wr) check(seen_wdata == wd, "R8 downstream wdata", seen_wdata, wd);
      else    check(rdata == {8'h5D, addr}, "R8 downstream rdata", rdata, {8'h5D, addr});
    end else begin
      if (wr) check(fn_cnt == f0 && ds_cnt == d0, "R4 write miss dropped", 32'(fn_cnt - f0 + ds_cnt - d0), 32'd0);
      else begin
        check(fn_cnt == f0 && ds_cnt == d0, "R2 miss not forwarded", 32'(fn_cnt - f0 + ds_cnt - d0), 32'd0);
        check(rdata == fill_of(len), "R3 miss fill", rdata, fill_of(len));
      end
    end
    @(negedge clk);
    check(done == 1'b0, "R10 done single cycle", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=finished");
    fails++; checks++;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 256; i++) fn_present[i] = $urandom % 2;
    fn_present[BRIDGE] = 1'b1;
    fn_present[8'h20]  = 1'b0;
    fn_present[8'h11]  = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready && !done && !fn_valid && !ds_valid && rdata == 0, "R10 reset state",
          {28'h0, req_ready, done, fn_valid, ds_valid}, 32'h8);
    // R9: secondary resets to 0; bus 0 stays local
    access(0, {LOCAL, 8'h11, 8'h04}, 0, 3'd4);
    // R3: miss fill by length
    access(0, {LOCAL, 8'h20, 8'h00}, 0, 3'd1);
    access(0, {LOCAL, 8'h20, 8'h02}, 0, 3'd2);
    access(0, {8'h33, 8'h11, 8'h00}, 0, 3'd4);
    access(0, {8'h33, 8'h11, 8'h00}, 0, 3'd3);
    // R4: write miss changes nothing
    access(1, {LOCAL, 8'h20, 8'h19}, 32'h0000_0044, 3'd1);
    access(0, {8'h44, 8'h00, 8'h00}, 0, 3'd4);
    // R5 + R7: offset 0x19 capture
    access(1, {LOCAL, BRIDGE, 8'h19}, 32'h0000_0005, 3'd1);
    check(model_sec == 8'h05, "R5 model", {24'h0, model_sec}, 32'h5);
    access(0, {8'h05, 8'h23, 8'h10}, 0, 3'd4);
    // R6: offset 0x18 length 2
    access(1, {LOCAL, BRIDGE, 8'h18}, 32'h0000_0701, 3'd2);
    access(1, {8'h07, 8'h40, 8'h3C}, 32'hCAFE_F00D, 3'd4);
    // R6: offset 0x18 length 1 leaves it
    access(1, {LOCAL, BRIDGE, 8'h18}, 32'h0000_0909, 3'd1);
    access(0, {8'h07, 8'h40, 8'h3C}, 0, 3'd2);
    access(0, {8'h09, 8'h40, 8'h3C}, 0, 3'd2);
    // R9: secondary equal to local -> local wins
    access(1, {LOCAL, BRIDGE, 8'h19}, 32'h0000_0000, 3'd4);
    access(0, {LOCAL, 8'h11, 8'h08}, 0, 3'd4);
    access(1, {LOCAL, BRIDGE, 8'h19}, 32'h0000_0012, 3'd1);
    // Random traffic
    for (int k = 0; k < 400; k++) begin
      logic [7:0] b, d, o;
      logic [2:0] l;
      int sel = $urandom % 4;
      b = (sel == 0) ? model_sec : (sel == 3) ? 8'($urandom) : LOCAL;
      d = ($urandom % 8 == 0) ? BRIDGE : 8'($urandom);
      o = ($urandom % 6 == 0) ? 8'h18 + 8'($urandom % 2) : 8'($urandom);
      l = ($urandom % 3 == 0) ? 3'd1 : ($urandom % 2 == 0) ? 3'd2 : 3'd4;
      access($urandom % 2, {b, d, o}, $urandom, l);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule